// File: doc/BRIEF.md
# Converter Serial Readout Controller

This controller sits on the host side of a 16-bit successive-approximation converter that returns its results over a serial line clocked by the host. For each request it pulses the convert-start strobe low with chip-select asserted. It follows the converter's busy flag, produces a gated burst of data-clock pulses from the system clock, and shifts the serial result in MSB first. When the word is complete it presents it on `data_o` with a one-cycle `valid_o` strobe.

There are two read modes. In the overlapped mode, the controller starts shifting as soon as busy falls. It therefore returns the word from the conversion before this one, and `prev_o` marks that word. In the post-conversion mode, the controller keeps chip-select high while the conversion runs, waits for busy to rise, and then reads the fresh result. In this mode a sync framing option can be turned on. The controller then sends an arming pulse with chip-select high, adds one slot in front of the MSB that carries the sync flag, and reports a framing error if that flag is not 1.

The data-clock half period is set at run time in system-clock cycles. It is clamped to a floor so that the pin limit cannot be exceeded. Each burst either samples on falling edges or samples one edge later on rising edges.

Top module: `adc_readout_ctrl`

## Requirements
- R1: Out of reset, conv_no_o and cs_no_o are 1 and dclk_o, valid_o, prev_o, frame_err_o and data_o are all 0.
- R2: A start_i pulse while idle drives conv_no_o low for exactly CONV_LOW (default 4) system cycles with cs_no_o low. A start_i that arrives while a read is in progress has no effect: it causes no second conversion and no second valid_o.
- R3: Overlapped mode (mode_i=0): once busy is seen low, the controller shifts in 16 bits MSB first while the conversion runs. data_o then holds the result of the previous conversion, and prev_o=1.
- R4: rise_cap_i=0 samples each bit on a falling dclk edge, with bit k on the falling edge of data pulse k. rise_cap_i=1 samples each bit on the next rising edge, which adds one pulse to the burst. A burst without a sync slot is 16 or 17 pulses.
- R5: Post-conversion mode (mode_i=1): cs_no_o is high while busy is low. The read begins after busy returns high and yields the result of this conversion, with prev_o=0.
- R6: With mode_i=1 and sync_en_i=1, the controller emits exactly one dclk pulse with cs_no_o high before the read. The burst grows by one pulse (17 for falling capture, 18 for rising capture). The first sampled slot is the sync flag, and the data starts in the second slot.
- R7: frame_err_o is 1 with a word only when sync framing was used and the sampled sync flag was 0. Otherwise it is 0.
- R8: In overlapped mode sync_en_i has no effect: there is no arming pulse, the burst keeps 16 or 17 pulses, and frame_err_o stays 0.
- R9: dclk_o is low outside a burst or arming pulse and never high while conv_no_o is low. Each high and low phase lasts max(half_div_i, MIN_HALF) cycles, with MIN_HALF=4 by default.
- R10: valid_o is a single-cycle pulse. data_o, prev_o and frame_err_o change only together with valid_o and hold their values until the next valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and read |
| mode_i | input | 1 | 0 overlapped read, 1 post-conversion read |
| sync_en_i | input | 1 | Sync framing in post-conversion mode |
| rise_cap_i | input | 1 | 1 samples on rising dclk edges |
| half_div_i | input | DIV_W | dclk half period in system cycles |
| busy_i | input | 1 | Converter busy flag, low while converting |
| sdata_i | input | 1 | Serial data from converter |
| conv_no_o | output | 1 | Convert-start strobe, active low |
| cs_no_o | output | 1 | Chip-select, active low |
| dclk_o | output | 1 | Gated data clock |
| data_o | output | DW | Captured result word |
| valid_o | output | 1 | One-cycle strobe for data_o |
| prev_o | output | 1 | Word belongs to previous conversion |
| frame_err_o | output | 1 | Sync flag was not 1 |

## Verification
A wrong pulse counter or a wrong capture-slot decode shows up as a word shifted by one bit or truncated, and `valid_o` is also early or late. Both are visible on the first read in the affected mode and edge setting. A wrong sync latch shows in one of two ways: a spurious arming pulse while chip-select is high, or a framing error raised against a good flag, both within that same transaction. A stuck sequencer state leaves `valid_o` absent and the strobes parked, which the bench detects within one burst time.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV, ST_WAIT_LO, ST_WAIT_HI, ST_SYNC, ST_SETUP, ST_BURST, ST_DONE
  } rd_state_e;

  typedef enum logic {
    RD_DURING = 1'b0,
    RD_AFTER  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/adc_rd_divider.sv
module adc_rd_divider #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_eff, cnt_q;

  assign half_eff = (half_i < MIN_V) ? MIN_V : half_i;
  assign tick_o   = en_i && (cnt_q == half_eff - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic          sync_slot_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o,
  output logic          sync_bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o     <= '0;
      sync_bit_o <= 1'b0;
    end else if (clear_i) begin
      word_o     <= '0;
      sync_bit_o <= 1'b0;
    end else if (sample_i) begin
      if (sync_slot_i) sync_bit_o <= bit_i;
      else             word_o     <= {word_o[DW-2:0], bit_i};
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq import adc_rd_pkg::*; #(
  parameter int unsigned DW        = 16,
  parameter int unsigned CONV_LOW  = 4,
  parameter int unsigned SETUP_CYC = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     mode_i,
  input  logic     sync_en_i,
  input  logic     rise_cap_i,
  input  logic     busy_i,
  input  logic     tick_i,
  output logic     conv_no_o,
  output logic     cs_no_o,
  output logic     dclk_o,
  output logic     div_en_o,
  output logic     sample_o,
  output logic     sync_slot_o,
  output logic     clear_o,
  output logic     done_o,
  output rd_mode_e mode_q_o,
  output logic     sync_q_o
);
  localparam int unsigned PW   = $clog2(DW + 3);
  localparam int unsigned CMAX = (CONV_LOW > SETUP_CYC) ? CONV_LOW : SETUP_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  rd_state_e     state_q;
  rd_mode_e      mode_q;
  logic          sync_q, rise_q, dclk_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pulse_q, total;

  assign total = PW'(DW) + PW'(sync_q) + PW'(rise_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= RD_DURING;
      sync_q  <= 1'b0;
      rise_q  <= 1'b0;
      dclk_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= rd_mode_e'(mode_i);
          sync_q  <= sync_en_i & mode_i;
          rise_q  <= rise_cap_i;
          cnt_q   <= '0;
          state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (cnt_q == CW'(CONV_LOW - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_WAIT_LO;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT_LO: if (!busy_i) state_q <= (mode_q == RD_AFTER) ? ST_WAIT_HI : ST_SETUP;
        ST_WAIT_HI: if (busy_i)  state_q <= sync_q ? ST_SYNC : ST_SETUP;
        ST_SYNC: if (tick_i) begin
          // arming pulse with chip-select high
          if (!dclk_q) dclk_q <= 1'b1;
          else begin
            dclk_q  <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q == CW'(SETUP_CYC - 1)) begin
            cnt_q   <= '0;
            pulse_q <= '0;
            state_q <= ST_BURST;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_BURST: if (tick_i) begin
          if (!dclk_q) begin
            dclk_q  <= 1'b1;
            pulse_q <= pulse_q + 1'b1;
          end else begin
            dclk_q <= 1'b0;
            if (pulse_q == total) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // slot index j equals pulse_q on both edges; slot 1 is the sync flag when framed
  always_comb begin
    sample_o    = 1'b0;
    sync_slot_o = 1'b0;
    if (state_q == ST_BURST && tick_i) begin
      if (!dclk_q) begin
        if (rise_q && pulse_q != '0) begin
          sample_o    = 1'b1;
          sync_slot_o = sync_q && (pulse_q == PW'(1));
        end
      end else if (!rise_q) begin
        sample_o    = 1'b1;
        sync_slot_o = sync_q && (pulse_q == PW'(1));
      end
    end
  end

  assign conv_no_o = (state_q != ST_CONV);
  assign cs_no_o   = !((state_q == ST_CONV) || (state_q == ST_SETUP) || (state_q == ST_BURST) ||
                       (state_q == ST_WAIT_LO && mode_q == RD_DURING));
  assign dclk_o    = dclk_q;
  assign div_en_o  = (state_q == ST_SYNC) || (state_q == ST_BURST);
  assign clear_o   = (state_q == ST_IDLE) && start_i;
  assign done_o    = (state_q == ST_DONE);
  assign mode_q_o  = mode_q;
  assign sync_q_o  = sync_q;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl import adc_rd_pkg::*; #(
  parameter int unsigned DW          = 16,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned MIN_HALF    = 4,
  parameter int unsigned CONV_LOW    = 4,
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             sync_en_i,
  input  logic             rise_cap_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             busy_i,
  input  logic             sdata_i,
  output logic             conv_no_o,
  output logic             cs_no_o,
  output logic             dclk_o,
  output logic [DW-1:0]    data_o,
  output logic             valid_o,
  output logic             prev_o,
  output logic             frame_err_o
);
  logic [SYNC_STAGES-1:0] busy_sq;
  logic busy_s, tick, div_en, sample, sync_slot, clear, done, sync_q, sync_bit;
  rd_mode_e mode_q;
  logic [DW-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_sq <= '1;
    else         busy_sq <= {busy_sq[SYNC_STAGES-2:0], busy_i};
  end
  assign busy_s = busy_sq[SYNC_STAGES-1];

  adc_rd_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) i_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(div_en), .half_i(half_div_i), .tick_o(tick)
  );

  adc_rd_seq #(.DW(DW), .CONV_LOW(CONV_LOW), .SETUP_CYC(SETUP_CYC)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .sync_en_i  (sync_en_i),
    .rise_cap_i (rise_cap_i),
    .busy_i     (busy_s),
    .tick_i     (tick),
    .conv_no_o  (conv_no_o),
    .cs_no_o    (cs_no_o),
    .dclk_o     (dclk_o),
    .div_en_o   (div_en),
    .sample_o   (sample),
    .sync_slot_o(sync_slot),
    .clear_o    (clear),
    .done_o     (done),
    .mode_q_o   (mode_q),
    .sync_q_o   (sync_q)
  );

  adc_rd_capture #(.DW(DW)) i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .sample_i   (sample),
    .sync_slot_i(sync_slot),
    .bit_i      (sdata_i),
    .word_o     (word),
    .sync_bit_o (sync_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      prev_o      <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= done;
      if (done) begin
        data_o      <= word;
        prev_o      <= (mode_q == RD_DURING);
        frame_err_o <= sync_q & ~sync_bit;
      end
    end
  end
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int unsigned DW       = 16,
  parameter int unsigned MIN_HALF = 4,
  parameter int unsigned CONV_LOW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_no_o,
  input logic          dclk_o,
  input logic [DW-1:0] data_o,
  input logic          valid_o,
  input logic          prev_o,
  input logic          frame_err_o
);
  logic [15:0] hi_cnt, lo_cnt, conv_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      conv_cnt <= '0;
    end else begin
      hi_cnt   <= dclk_o ? hi_cnt + 1'b1 : '0;
      lo_cnt   <= dclk_o ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
      conv_cnt <= conv_no_o ? '0 : conv_cnt + 1'b1;
    end
  end

  a_r9_dclk_conv_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_no_o |-> !dclk_o);

  a_r9_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dclk_o) |-> hi_cnt >= 16'(MIN_HALF));

  a_r9_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dclk_o) && lo_cnt != 16'hFFFF) |-> lo_cnt >= 16'(MIN_HALF));

  a_r2_conv_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_no_o) |-> conv_cnt == 16'(CONV_LOW));

  a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(prev_o) && $stable(frame_err_o)));

  a_r7_ferr_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !prev_o);
endmodule

bind adc_readout_ctrl adc_rd_checker #(.DW(DW), .MIN_HALF(MIN_HALF), .CONV_LOW(CONV_LOW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .conv_no_o  (conv_no_o),
  .dclk_o     (dclk_o),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .prev_o     (prev_o),
  .frame_err_o(frame_err_o)
);

// File: tb/test_adc_readout_ctrl.sv
`timescale 1ns/1ps
module test_adc_readout_ctrl;
  localparam int PERIOD   = 10;
  localparam int BUSY_CYC = 700;
  localparam int NVEC     = 9;

  // {mode, sync, rise, div[7:0], sync_flag, value[15:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'd4, 1'b1, 16'h1234},
    {1'b0, 1'b0, 1'b1, 8'd6, 1'b1, 16'hBEEF},
    {1'b1, 1'b0, 1'b0, 8'd4, 1'b1, 16'h8001},
    {1'b1, 1'b0, 1'b1, 8'd5, 1'b1, 16'h7FFE},
    {1'b1, 1'b1, 1'b0, 8'd4, 1'b1, 16'hC3A5},
    {1'b1, 1'b1, 1'b1, 8'd4, 1'b1, 16'h0F0F},
    {1'b1, 1'b1, 1'b0, 8'd4, 1'b0, 16'hFFFF},
    {1'b0, 1'b1, 1'b0, 8'd1, 1'b1, 16'h5A5A},
    {1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 16'h0000}
  };

  logic clk = 0, rst_n = 0, start = 0, mode = 0, sync_en = 0, rise_cap = 0;
  logic [7:0] half_div = 8'd4;
  logic busy = 1, sdata = 0;
  logic conv_n, cs_n, dclk, valid, prev, ferr;
  logic [15:0] data;

  int n_tests = 0, n_fail = 0;
  logic [15:0] last_res = 16'hA5C3, conv_val = 0, sh = 0;
  logic sflag_val = 1, armed = 0;
  int k = 0, pre_cnt = 0, burst_cnt = 0, conv_falls = 0, valid_cnt = 0;
  realtime t_rise = 0, t_conv = 0;
  int half_meas = 0, conv_w = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_readout_ctrl i_adc_readout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .sync_en_i(sync_en),
    .rise_cap_i(rise_cap), .half_div_i(half_div), .busy_i(busy), .sdata_i(sdata),
    .conv_no_o(conv_n), .cs_no_o(cs_n), .dclk_o(dclk), .data_o(data), .valid_o(valid),
    .prev_o(prev), .frame_err_o(ferr)
  );

  // converter model
  always @(negedge conv_n) begin
    conv_falls++;
    t_conv = $realtime;
    repeat (3) @(posedge clk);
    busy <= 1'b0;
    repeat (BUSY_CYC) @(posedge clk);
    last_res = conv_val;
    busy <= 1'b1;
  end
  always @(posedge conv_n) conv_w = int'(($realtime - t_conv) / PERIOD);
  always @(negedge cs_n) begin k = 0; sh = last_res; end
  always @(posedge cs_n) armed = 0;
  always @(posedge dclk) begin
    t_rise = $realtime;
    if (cs_n) begin
      armed = 1;
      pre_cnt++;
    end else begin
      burst_cnt++;
      k++;
      #1;
      if (armed) sdata = (k == 1) ? sflag_val : ((k >= 2 && k <= 17) ? sh[17-k] : 1'b0);
      else       sdata = (k >= 1 && k <= 16) ? sh[16-k] : 1'b0;
    end
  end
  always @(negedge dclk) half_meas = int'(($realtime - t_rise) / PERIOD);
  always @(posedge clk) if (valid) valid_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 6000; t++) begin
      @(negedge clk);
      if (valid) break;
    end
  endtask

  task automatic settle();
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic run_vec(input logic [27:0] v);
    logic [15:0] exp_d;
    int exp_half, exp_burst, exp_pre;
    logic s;
    mode = v[27]; sync_en = v[26]; rise_cap = v[25]; half_div = v[24:17];
    sflag_val = v[16]; conv_val = v[15:0];
    s = v[27] & v[26];
    exp_d = v[27] ? v[15:0] : last_res;
    exp_half = (v[24:17] < 4) ? 4 : int'(v[24:17]);
    exp_burst = 16 + int'(s) + int'(v[25]);
    exp_pre = int'(s);
    pre_cnt = 0; burst_cnt = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    wait_valid();
    chk("R10 valid", {31'd0, valid}, 32'd1);
    chk(v[27] ? "R5 data" : "R3 data", {16'd0, data}, {16'd0, exp_d});
    chk(v[27] ? "R5 prev" : "R3 prev", {31'd0, prev}, {31'd0, ~v[27]});
    chk("R7 frame_err", {31'd0, ferr}, {31'd0, s & ~v[16]});
    chk(v[25] ? "R4 rise burst pulses" : "R4 fall burst pulses", burst_cnt, exp_burst);
    chk(v[27] ? "R6 arming pulses" : "R8 arming pulses", pre_cnt, exp_pre);
    chk("R9 half period", half_meas, exp_half);
    @(negedge clk);
    chk("R10 valid single", {31'd0, valid}, 32'd0);
    chk("R10 data hold", {16'd0, data}, {16'd0, exp_d});
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 conv_n", {31'd0, conv_n}, 32'd1);
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 dclk", {31'd0, dclk}, 32'd0);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 data", {16'd0, data}, 32'd0);
    chk("R1 flags", {30'd0, prev, ferr}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R2: start ignored while busy, strobe width
    conv_falls = 0; valid_cnt = 0;
    mode = 1; sync_en = 0; rise_cap = 0; half_div = 8'd4; conv_val = 16'h3C3C;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (2) @(negedge clk);
    chk("R2 cs_n low with convert", {31'd0, cs_n}, 32'd0);
    repeat (30) @(negedge clk);
    start = 1;
    @(negedge clk) start = 0;
    wait_valid();
    chk("R2 data", {16'd0, data}, 32'h3C3C);
    settle();
    repeat (50) @(negedge clk);
    chk("R2 conv count", conv_falls, 1);
    chk("R2 valid count", valid_cnt, 1);
    chk("R2 conv width", conv_w, 4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule